// File: doc/BRIEF.md
# Sample Output Coder

This block sits between the two 8-bit conversion channels of a converter and the output pad logic. Each incoming sample is unsigned (offset binary). The block recodes it to two's complement, Gray code or offset binary, registers the result and delays the valid strobe to match. A single control register sets the data format in its low field and the physical output mode in its high field. When a field holds the "follow the pins" code, a setting decoded from external strap pins takes its place.

The output mode field is decoded into three level signals for the pad drivers: differential signalling, single-ended signalling, and high drive strength. The register is written and read over a simple address/data bus. A soft reset flushes the sample pipeline but leaves the register intact. Only the hard reset clears it.

Top module: `sample_out_coder`

## Requirements
- R1: With format field (register bits [2:0]) = 3'b100, each output lane equals its input sample unchanged (offset binary).
- R2: With format field = 3'b001, each output lane equals its input sample with the most significant bit inverted (two's complement).
- R3: With format field = 3'b010, each output lane equals s ^ (s >> 1) of its input sample s (Gray code).
- R4: With format field = 3'b000, the strap input `pin_fmt` picks the format: 2'b00 two's complement, 2'b01 Gray code, 2'b10 or 2'b11 offset binary.
- R5: Any other format field value (011, 101, 110, 111) behaves exactly like 3'b000.
- R6: Mode field (register bits [7:5]) = 3'b001 gives `mode_lvds`=1 with `drive_hi`=0, 3'b010 gives `mode_lvds`=1 with `drive_hi`=1, and 3'b100 gives `mode_lvcmos`=1 with `drive_hi`=0. Exactly one of `mode_lvds`/`mode_lvcmos` is high, and `drive_hi` is only high together with `mode_lvds`.
- R7: Mode field 3'b000 or any unlisted value defers to `pin_mode`: 2'b00 differential low drive, 2'b01 differential high drive, 2'b10 or 2'b11 single-ended.
- R8: A sample accepted with `in_valid` at a clock edge appears on `out_data` with `out_valid` high after that same edge, one cycle of latency. Channel c occupies bits [8c+7:8c]. `out_valid` is low after any edge where `in_valid` was low.
- R9: A write changes the register only when `reg_addr` = 8'h73. `reg_rdata` returns the register at 8'h73 and zero at any other address.
- R10: While `soft_rst_n` is low, `out_valid` and `out_data` clear at the next edge, and the register keeps its value.
- R11: While `rst_n` is low, the register clears to 8'h00 (both fields follow the pins) and `out_valid`/`out_data` clear at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Hard reset, synchronous, active low |
| soft_rst_n | input | 1 | Soft reset, synchronous, active low; spares the register |
| in_valid | input | 1 | Input samples valid |
| in_data | input | 16 | Raw unsigned samples, channel 0 in the low byte |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register bus address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| pin_fmt | input | 2 | Decoded strap setting for data format |
| pin_mode | input | 2 | Decoded strap setting for output mode |
| out_valid | output | 1 | Coded samples valid |
| out_data | output | 16 | Coded samples, channel 0 in the low byte |
| mode_lvds | output | 1 | Differential output mode selected |
| mode_lvcmos | output | 1 | Single-ended output mode selected |
| drive_hi | output | 1 | High differential drive strength selected |

## Verification
Each format is driven with 8'h00, 8'h7F, 8'h80, 8'hFF and mixed patterns such as 8'h55 and 8'hA3. The midscale codes tell two's complement apart from pass-through, and the alternating patterns tell Gray code apart from both. The two channels always carry different values, so a lane swap or a shared lane shows up. Back-to-back streams followed by idle cycles expose latency and valid alignment errors. Every strap combination and several unlisted field codes are run both against the register override and without it.

// File: rtl/coder_pkg.sv
// Package: shared types and field decoding for the sample output coder.
// Assumes 3-bit register fields and 2-bit already-decoded strap inputs.
package coder_pkg;

    localparam int FIELD_W = 3;
    localparam int PIN_W   = 2;

    // Register field codes; anything else falls back to the straps.
    localparam logic [FIELD_W-1:0] FLD_PIN  = 3'b000;
    localparam logic [FIELD_W-1:0] FLD_OPT0 = 3'b001;
    localparam logic [FIELD_W-1:0] FLD_OPT1 = 3'b010;
    localparam logic [FIELD_W-1:0] FLD_OPT2 = 3'b100;

    typedef enum logic [1:0] {
        FMT_TWOS = 2'd0,
        FMT_GRAY = 2'd1,
        FMT_OBIN = 2'd2
    } fmt_e;

    typedef enum logic [1:0] {
        MODE_DIFF_LO = 2'd0,
        MODE_DIFF_HI = 2'd1,
        MODE_SINGLE  = 2'd2
    } mode_e;

    // Strap decode for the format: 0 twos, 1 gray, 2/3 offset binary.
    function automatic fmt_e pin_to_fmt(input logic [PIN_W-1:0] pin);
        case (pin)
            2'd0:    return FMT_TWOS;
            2'd1:    return FMT_GRAY;
            default: return FMT_OBIN;
        endcase
    endfunction

    // Strap decode for the mode: 0 diff low, 1 diff high, 2/3 single-ended.
    function automatic mode_e pin_to_mode(input logic [PIN_W-1:0] pin);
        case (pin)
            2'd0:    return MODE_DIFF_LO;
            2'd1:    return MODE_DIFF_HI;
            default: return MODE_SINGLE;
        endcase
    endfunction

endpackage

// File: rtl/ocd_ctrl_reg.sv
// Module: control register holding the format and mode fields.
// Assumes a single-cycle write strobe. Only the hard reset clears the
// register; the soft reset is deliberately not an input here.
module ocd_ctrl_reg
    import coder_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h73,
    parameter int                FMT_LSB  = 0,
    parameter int                MODE_LSB = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [FIELD_W-1:0] fmt_field,
    output logic [FIELD_W-1:0] mode_field
);

    logic [DATA_W-1:0] ctrl_q;
    logic              hit;

    assign hit = (addr == REG_ADDR);

    // Purpose: capture a write aimed at this register's address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && hit) begin
            ctrl_q <= wdata;
        end
    end

    // Purpose: return the register only when its address is presented.
    always_comb begin
        rdata = hit ? ctrl_q : '0;
    end

    assign fmt_field  = ctrl_q[FMT_LSB  +: FIELD_W];
    assign mode_field = ctrl_q[MODE_LSB +: FIELD_W];

endmodule

// File: rtl/ocd_sel_resolve.sv
// Module: resolves the register fields against the strap inputs.
// Assumes the straps are already decoded to 2-bit codes. An unlisted
// field code is treated like the explicit pin-control code.
module ocd_sel_resolve
    import coder_pkg::*;
(
    input  logic [FIELD_W-1:0] fmt_field,
    input  logic [FIELD_W-1:0] mode_field,
    input  logic [PIN_W-1:0]   pin_fmt,
    input  logic [PIN_W-1:0]   pin_mode,
    output fmt_e               fmt_sel,
    output mode_e              mode_sel
);

    // Purpose: pick the data format from the register or the strap.
    always_comb begin
        case (fmt_field)
            FLD_OPT0: fmt_sel = FMT_TWOS;
            FLD_OPT1: fmt_sel = FMT_GRAY;
            FLD_OPT2: fmt_sel = FMT_OBIN;
            default:  fmt_sel = pin_to_fmt(pin_fmt);
        endcase
    end

    // Purpose: pick the output mode from the register or the strap.
    always_comb begin
        case (mode_field)
            FLD_OPT0: mode_sel = MODE_DIFF_LO;
            FLD_OPT1: mode_sel = MODE_DIFF_HI;
            FLD_OPT2: mode_sel = MODE_SINGLE;
            default:  mode_sel = pin_to_mode(pin_mode);
        endcase
    end

endmodule

// File: rtl/ocd_lane_encode.sv
// Module: combinational recoder for one channel lane.
// Assumes the raw sample is unsigned (offset binary) and at least 2 bits.
module ocd_lane_encode
    import coder_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  fmt_e                raw_fmt,
    input  logic [SAMPLE_W-1:0] raw,
    output logic [SAMPLE_W-1:0] coded
);

    // Purpose: apply the selected code to the raw sample.
    always_comb begin
        case (raw_fmt)
            FMT_TWOS: coded = {~raw[SAMPLE_W-1], raw[SAMPLE_W-2:0]};
            FMT_GRAY: coded = raw ^ (raw >> 1);
            default:  coded = raw;
        endcase
    end

endmodule

// File: rtl/sample_out_coder.sv
// Module: top of the sample output coder.
// Recodes NUM_CH lanes of unsigned samples with one cycle of latency and
// decodes the output mode. Assumes the soft and hard resets are both
// synchronous and active low.
module sample_out_coder
    import coder_pkg::*;
#(
    parameter int                SAMPLE_W = 8,
    parameter int                NUM_CH   = 2,
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h73
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         soft_rst_n,
    input  logic                         in_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0]   in_data,
    input  logic                         reg_wr_en,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [DATA_W-1:0]            reg_wdata,
    output logic [DATA_W-1:0]            reg_rdata,
    input  logic [PIN_W-1:0]             pin_fmt,
    input  logic [PIN_W-1:0]             pin_mode,
    output logic                         out_valid,
    output logic [NUM_CH*SAMPLE_W-1:0]   out_data,
    output logic                         mode_lvds,
    output logic                         mode_lvcmos,
    output logic                         drive_hi
);

    localparam int BUS_W = NUM_CH * SAMPLE_W;

    logic [FIELD_W-1:0] fmt_field;
    logic [FIELD_W-1:0] mode_field;
    fmt_e               fmt_sel;
    mode_e              mode_sel;
    logic [BUS_W-1:0]   coded;
    logic               pipe_clr;

    ocd_ctrl_reg #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .REG_ADDR (REG_ADDR),
        .FMT_LSB  (0),
        .MODE_LSB (5)
    ) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .fmt_field  (fmt_field),
        .mode_field (mode_field)
    );

    ocd_sel_resolve u_sel (
        .fmt_field  (fmt_field),
        .mode_field (mode_field),
        .pin_fmt    (pin_fmt),
        .pin_mode   (pin_mode),
        .fmt_sel    (fmt_sel),
        .mode_sel   (mode_sel)
    );

    // One encoder per channel lane.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        ocd_lane_encode #(
            .SAMPLE_W (SAMPLE_W)
        ) u_enc (
            .raw_fmt (fmt_sel),
            .raw     (in_data[ch*SAMPLE_W +: SAMPLE_W]),
            .coded   (coded[ch*SAMPLE_W +: SAMPLE_W])
        );
    end

    assign pipe_clr = !rst_n || !soft_rst_n;

    // Purpose: delay the valid strobe by one cycle; either reset flushes it.
    always_ff @(posedge clk) begin
        if (pipe_clr) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Purpose: register coded samples on accepted inputs only.
    always_ff @(posedge clk) begin
        if (pipe_clr) begin
            out_data <= '0;
        end else if (in_valid) begin
            out_data <= coded;
        end
    end

    // Purpose: expand the resolved mode into the pad control levels.
    always_comb begin
        mode_lvds   = (mode_sel == MODE_DIFF_LO) || (mode_sel == MODE_DIFF_HI);
        mode_lvcmos = (mode_sel == MODE_SINGLE);
        drive_hi    = (mode_sel == MODE_DIFF_HI);
    end

endmodule

// File: rtl/sample_out_coder_chk.sv
// Module: assertion checker bound to the sample output coder top.
// Observes ports and the register fields; drives nothing.
module sample_out_coder_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h73
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst_n,
    input logic              in_valid,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [2:0]        fmt_field,
    input logic [2:0]        mode_field,
    input logic              out_valid,
    input logic              mode_lvds,
    input logic              mode_lvcmos,
    input logic              drive_hi
);

    assert_valid_follow_R8: assert property (@(posedge clk)
        disable iff (!rst_n || !soft_rst_n) in_valid |=> out_valid);

    assert_valid_idle_R8: assert property (@(posedge clk)
        disable iff (!rst_n || !soft_rst_n) !in_valid |=> !out_valid);

    assert_soft_flush_R10: assert property (@(posedge clk)
        disable iff (!rst_n) !soft_rst_n |=> !out_valid);

    assert_reg_hold_R9: assert property (@(posedge clk)
        disable iff (!rst_n)
        !(reg_wr_en && (reg_addr == REG_ADDR)) |=> ($stable(fmt_field) && $stable(mode_field)));

    assert_mode_single_R6: assert property (@(posedge clk)
        disable iff (!rst_n) $countones({mode_lvds, mode_lvcmos}) == 1);

    assert_drive_diff_R6: assert property (@(posedge clk)
        disable iff (!rst_n) drive_hi |-> mode_lvds);

    assert_hard_clear_R11: assert property (@(posedge clk)
        !rst_n |=> (fmt_field == 3'b000 && mode_field == 3'b000 && !out_valid));

endmodule

bind sample_out_coder sample_out_coder_chk #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst_n  (soft_rst_n),
    .in_valid    (in_valid),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .fmt_field   (fmt_field),
    .mode_field  (mode_field),
    .out_valid   (out_valid),
    .mode_lvds   (mode_lvds),
    .mode_lvcmos (mode_lvcmos),
    .drive_hi    (drive_hi)
);

// File: tb/sample_out_coder_bench.sv
// Scoreboard bench: the driver queues expected coded words, and the monitor
// pops and compares them whenever out_valid is seen.
module sample_out_coder_bench;

    localparam logic [7:0] REG_A = 8'h73;

    logic        clk = 1'b0;
    logic        rst_n, soft_rst_n, in_valid, reg_wr_en;
    logic [15:0] in_data;
    logic [7:0]  reg_addr, reg_wdata, reg_rdata;
    logic [1:0]  pin_fmt, pin_mode;
    logic        out_valid, mode_lvds, mode_lvcmos, drive_hi;
    logic [15:0] out_data;

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;
    logic [7:0]  model_reg = 8'h00;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    sample_out_coder u_sample_out_coder (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
        .in_valid(in_valid), .in_data(in_data),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pin_fmt(pin_fmt), .pin_mode(pin_mode),
        .out_valid(out_valid), .out_data(out_data),
        .mode_lvds(mode_lvds), .mode_lvcmos(mode_lvcmos), .drive_hi(drive_hi)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected format: 0 twos, 1 gray, 2 offset binary.
    function automatic int eff_fmt();
        case (model_reg[2:0])
            3'b001:  return 0;
            3'b010:  return 1;
            3'b100:  return 2;
            default: return (pin_fmt == 2'b00) ? 0 : (pin_fmt == 2'b01) ? 1 : 2;
        endcase
    endfunction

    // Expected mode levels {lvds, lvcmos, drive_hi}.
    function automatic logic [2:0] eff_mode();
        logic [1:0] m;
        case (model_reg[7:5])
            3'b001:  m = 2'd0;
            3'b010:  m = 2'd1;
            3'b100:  m = 2'd2;
            default: m = (pin_mode == 2'b00) ? 2'd0 : (pin_mode == 2'b01) ? 2'd1 : 2'd2;
        endcase
        case (m)
            2'd0:    return 3'b100;
            2'd1:    return 3'b101;
            default: return 3'b010;
        endcase
    endfunction

    function automatic logic [7:0] enc(input logic [7:0] s, input int f);
        if (f == 0) return s ^ 8'h80;
        if (f == 1) return s ^ {1'b0, s[7:1]};
        return s;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_addr = REG_A;
        if (a == REG_A) model_reg = d;
    endtask

    task automatic send(input logic [7:0] c0, input logic [7:0] c1, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = {c1, c0};
        exp_q.push_back({enc(c1, eff_fmt()), enc(c0, eff_fmt())});
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic burst(input string tag);
        send(8'h00, 8'hFF, tag);
        send(8'h7F, 8'h80, tag);
        send(8'h55, 8'hA3, tag);
        send(8'hC6, 8'h3C, tag);
        idle();
    endtask

    task automatic check_mode(input string tag);
        #1;
        check(tag, {13'd0, mode_lvds, mode_lvcmos, drive_hi}, {13'd0, eff_mode()});
    endtask

    // Monitor: compare each valid output word with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected out_valid", 16'd1, 16'd0);
            end else begin
                check(tag_q.pop_front(), out_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; soft_rst_n = 1'b1; in_valid = 1'b0; in_data = '0;
        reg_wr_en = 1'b0; reg_addr = REG_A; reg_wdata = '0;
        pin_fmt = 2'b10; pin_mode = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset out_valid", {15'd0, out_valid}, 16'd0);
        check("R11 reset register", {8'd0, reg_rdata}, 16'd0);

        // R4: straps decide the format
        for (int p = 0; p < 4; p++) begin
            pin_fmt = p[1:0];
            burst("R4 pin format");
        end

        wr(REG_A, 8'h04); burst("R1 offset binary");
        wr(REG_A, 8'h01); burst("R2 twos complement");
        wr(REG_A, 8'h02); burst("R3 gray code");
        // R8: out_valid low after idle cycles
        check("R8 idle out_valid", {15'd0, out_valid}, 16'd0);

        // R5: unlisted format codes fall back to the straps
        pin_fmt = 2'b01;
        wr(REG_A, 8'h03); burst("R5 code 011");
        wr(REG_A, 8'h07); burst("R5 code 111");
        pin_fmt = 2'b00;
        wr(REG_A, 8'h05); burst("R5 code 101");
        wr(REG_A, 8'h06); burst("R5 code 110");

        // R6: explicit mode codes
        wr(REG_A, 8'h20); check_mode("R6 diff low");
        wr(REG_A, 8'h40); check_mode("R6 diff high");
        wr(REG_A, 8'h80); check_mode("R6 single-ended");

        // R7: mode follows straps for 000 and unlisted codes
        for (int p = 0; p < 4; p++) begin
            pin_mode = p[1:0];
            wr(REG_A, 8'h00); check_mode("R7 pin mode");
            wr(REG_A, 8'h60); check_mode("R7 code 011");
            wr(REG_A, 8'hE0); check_mode("R7 code 111");
        end

        // R9: writes elsewhere ignored, readback decode
        wr(REG_A, 8'h04);
        wr(8'h74, 8'h02);
        wr(8'h72, 8'h41);
        reg_addr = REG_A; #1;
        check("R9 readback after stray writes", {8'd0, reg_rdata}, 16'h0004);
        reg_addr = 8'h74; #1;
        check("R9 other address reads zero", {8'd0, reg_rdata}, 16'h0000);
        reg_addr = REG_A;
        burst("R9 format unchanged");

        // R10: soft reset flushes outputs, keeps the register
        wr(REG_A, 8'h42);
        send(8'h12, 8'hE7, "R10 before soft reset");
        idle();
        @(negedge clk);
        soft_rst_n = 1'b0;
        in_valid = 1'b1; in_data = 16'h5A5A;
        @(negedge clk);
        check("R10 soft out_valid", {15'd0, out_valid}, 16'd0);
        check("R10 soft out_data", out_data, 16'h0000);
        in_valid = 1'b0;
        @(negedge clk);
        soft_rst_n = 1'b1;
        reg_addr = REG_A; #1;
        check("R10 register kept", {8'd0, reg_rdata}, 16'h0042);
        check_mode("R10 mode kept");
        burst("R10 format kept");

        // R11: hard reset clears the register
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 hard out_valid", {15'd0, out_valid}, 16'd0);
        rst_n = 1'b1;
        model_reg = 8'h00;
        #1;
        check("R11 hard register", {8'd0, reg_rdata}, 16'h0000);
        check_mode("R11 mode after reset");
        burst("R11 pins after reset");

        repeat (3) @(negedge clk);
        check("R8 scoreboard drained", exp_q.size(), 16'd0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule